// File: doc/BRIEF.md
# Per-Bank Open-Row Sequencer

This block sits between a user request port and the SDRAM command bus of a memory controller. A requester raises a write or read request together with a flat address, a burst length and a close-after-access flag. The block splits the address into bank, row and column, looks up what it last did to that bank, and issues the shortest command sequence that gets to the column access. That sequence is column only, activate then column, or precharge then activate then column. It holds the required gaps between these commands. It acknowledges the request one cycle after the column command.

For every bank the block keeps the row it last opened and a flag that says whether the bank is open. The flag is set by its own activates. It is cleared by its own precharges, by column commands that carry auto-precharge, and by a precharge-all event that the refresh logic reports on a separate input.

The controller is a single state machine:
- `S_IDLE` accepts a request and moves to `S_CHECK`.
- `S_CHECK` goes to `S_COL` on a row hit, to `S_PRE` when the bank is open on another row, and to `S_ACT` when the bank is closed.
- `S_PRE` always moves to `S_WAIT_RP`.
- `S_WAIT_RP` moves to `S_ACT` when its counter expires.
- `S_ACT` always moves to `S_WAIT_RCD`.
- `S_WAIT_RCD` moves to `S_COL` when its counter expires.
- `S_COL` always moves to `S_ACK`.
- `S_ACK` always returns to `S_IDLE`.

Top module: `bank_row_sequencer`

## Requirements
- R1: The request address is laid out as {bank, row, column}, with the bank in the most significant bits and the column in the least. Activate commands carry the bank and row fields, and column commands carry the bank and column fields.
- R2: A request to a closed bank produces an activate to the requested row and then the column command, with no precharge.
- R3: A request to an open bank holding a different row produces a precharge to that bank, then an activate to the requested row, then the column command.
- R4: A request to an open bank already holding the requested row produces the column command alone.
- R5: The activate follows the precharge by exactly TRP cycles, and the column command follows the activate by exactly TRCD cycles.
- R6: `req_ack` is high for exactly one cycle, the cycle right after the column command, and no command is issued in that cycle.
- R7: With `auto_close` set, the column command has `cmd_auto_pre` high and the bank is marked closed, so the next access to it starts with an activate even for the same row.
- R8: A one-cycle pulse on `pall_seen` marks every bank closed.
- R9: Command codes on `cmd_code` are: 0 no-op, 1 precharge, 2 activate, 3 read, 4 write. When `wr_req` and `rd_req` are both high, the write is taken.
- R10: After reset every bank is closed, `cmd_code` is 0, and `req_ack` and `busy` are low.
- R11: `busy` is high from the cycle after a request is accepted through the acknowledge cycle, and low again the cycle after. Requests are sampled only while idle.
- R12: The column command carries the request's burst length on `cmd_burst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Write request, held until acknowledged |
| rd_req | input | 1 | Read request, held until acknowledged |
| req_addr | input | BANK_W+ROW_W+COL_W | Start address {bank, row, column} |
| burst_len | input | BL_W | Burst length of the request |
| auto_close | input | 1 | Issue the column command with auto-precharge |
| pall_seen | input | 1 | Precharge-all issued by the refresh logic |
| req_ack | output | 1 | One-cycle acknowledge |
| busy | output | 1 | A request is in progress |
| cmd_code | output | 3 | Command issued this cycle |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Row for activate |
| cmd_col | output | COL_W | Column for read/write |
| cmd_auto_pre | output | 1 | Auto-precharge on the column command |
| cmd_burst | output | BL_W | Burst length on the column command |

## Verification
The checks assume that the precharge-all report arrives only while the block is idle. They also assume that a requester keeps its request stable until the acknowledge and then drops it. The bench only pulses `pall_seen` between requests, and it drops its request lines on the half cycle after it sees `req_ack`. Under these conditions the flag for the target bank decides whether a precharge or an activate is legal, and the assertions hold the gap rules against command history counted in the checker.

// File: rtl/brs_pkg.sv
package brs_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_PRE = 3'd1,
        CMD_ACT = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_PRE,
        S_WAIT_RP,
        S_ACT,
        S_WAIT_RCD,
        S_COL,
        S_ACK
    } state_e;

endpackage

// File: rtl/brs_addr_split.sv
module brs_addr_split #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    localparam int ADDR_W = BANK_W + ROW_W + COL_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);
    // Bank occupies the top bits, column the bottom bits.
    assign bank = addr[ADDR_W-1 -: BANK_W];
    assign row  = addr[COL_W +: ROW_W];
    assign col  = addr[COL_W-1:0];
endmodule

// File: rtl/brs_bank_table.sv
module brs_bank_table #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    localparam int NB    = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              set_open,
    input  logic              set_close,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row,
    input  logic [BANK_W-1:0] look_bank,
    output logic              look_open,
    output logic [ROW_W-1:0]  look_row,
    output logic [NB-1:0]     open_vec
);
    logic [ROW_W-1:0] row_arr [NB];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic             open_q;
        logic [ROW_W-1:0] row_q;
        logic             hit;

        assign hit = (upd_bank == BANK_W'(b));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q <= 1'b0;
                row_q  <= '0;
            end else if (clr_all) begin
                open_q <= 1'b0;
            end else if (set_open && hit) begin
                open_q <= 1'b1;
                row_q  <= upd_row;
            end else if (set_close && hit) begin
                open_q <= 1'b0;
            end
        end

        assign open_vec[b] = open_q;
        assign row_arr[b]  = row_q;
    end

    assign look_open = open_vec[look_bank];
    assign look_row  = row_arr[look_bank];
endmodule

// File: rtl/brs_delay_cnt.sv
module brs_delay_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/bank_row_sequencer.sv
module bank_row_sequencer
    import brs_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    parameter int BL_W   = 4,
    parameter int TRP    = 3,
    parameter int TRCD   = 3,
    localparam int ADDR_W = BANK_W + ROW_W + COL_W,
    localparam int NB     = 1 << BANK_W,
    localparam int TMAX   = (TRP > TRCD) ? TRP : TRCD,
    localparam int CNT_W  = $clog2(TMAX) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BL_W-1:0]   burst_len,
    input  logic              auto_close,
    input  logic              pall_seen,
    output logic              req_ack,
    output logic              busy,
    output logic [2:0]        cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_auto_pre,
    output logic [BL_W-1:0]   cmd_burst
);
    localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(TRP - 2);
    localparam logic [CNT_W-1:0] RCD_LOAD = CNT_W'(TRCD - 2);

    state_e state_q, state_d;
    cmd_e   cmd_d;

    logic              lat_wr;
    logic              lat_ap;
    logic [BANK_W-1:0] lat_bank;
    logic [ROW_W-1:0]  lat_row;
    logic [COL_W-1:0]  lat_col;
    logic [BL_W-1:0]   lat_bl;

    logic [BANK_W-1:0] dec_bank;
    logic [ROW_W-1:0]  dec_row;
    logic [COL_W-1:0]  dec_col;

    logic              tab_open;
    logic [ROW_W-1:0]  tab_row;
    logic [NB-1:0]     open_vec;
    logic              set_open, set_close;

    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_val;
    logic              cnt_zero;
    logic              take;

    brs_addr_split #(
        .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
    ) u_split (
        .addr(req_addr), .bank(dec_bank), .row(dec_row), .col(dec_col)
    );

    brs_bank_table #(
        .BANK_W(BANK_W), .ROW_W(ROW_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (pall_seen),
        .set_open  (set_open),
        .set_close (set_close),
        .upd_bank  (lat_bank),
        .upd_row   (lat_row),
        .look_bank (lat_bank),
        .look_open (tab_open),
        .look_row  (tab_row),
        .open_vec  (open_vec)
    );

    brs_delay_cnt #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
    );

    assign take = (state_q == S_IDLE) && (wr_req || rd_req);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture (write wins when both are raised)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_wr   <= 1'b0;
            lat_ap   <= 1'b0;
            lat_bank <= '0;
            lat_row  <= '0;
            lat_col  <= '0;
            lat_bl   <= '0;
        end else if (take) begin
            lat_wr   <= wr_req;
            lat_ap   <= auto_close;
            lat_bank <= dec_bank;
            lat_row  <= dec_row;
            lat_col  <= dec_col;
            lat_bl   <= burst_len;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (take) state_d = S_CHECK;
            end
            S_CHECK: begin
                if (tab_open && (tab_row == lat_row)) state_d = S_COL;
                else if (tab_open)                   state_d = S_PRE;
                else                                 state_d = S_ACT;
            end
            S_PRE:      state_d = S_WAIT_RP;
            S_WAIT_RP: begin
                if (cnt_zero) state_d = S_ACT;
            end
            S_ACT:      state_d = S_WAIT_RCD;
            S_WAIT_RCD: begin
                if (cnt_zero) state_d = S_COL;
            end
            S_COL:      state_d = S_ACK;
            S_ACK:      state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // Output and side-effect logic
    always_comb begin
        cmd_d     = CMD_NOP;
        set_open  = 1'b0;
        set_close = 1'b0;
        cnt_load  = 1'b0;
        cnt_val   = '0;
        req_ack   = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            S_IDLE:  busy = 1'b0;
            S_CHECK: ;
            S_PRE: begin
                cmd_d     = CMD_PRE;
                set_close = 1'b1;
                cnt_load  = 1'b1;
                cnt_val   = RP_LOAD;
            end
            S_WAIT_RP: ;
            S_ACT: begin
                cmd_d    = CMD_ACT;
                set_open = 1'b1;
                cnt_load = 1'b1;
                cnt_val  = RCD_LOAD;
            end
            S_WAIT_RCD: ;
            S_COL: begin
                cmd_d     = lat_wr ? CMD_WR : CMD_RD;
                set_close = lat_ap;
            end
            S_ACK:   req_ack = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    assign cmd_code     = cmd_d;
    assign cmd_bank     = lat_bank;
    assign cmd_row      = lat_row;
    assign cmd_col      = lat_col;
    assign cmd_auto_pre = (state_q == S_COL) && lat_ap;
    assign cmd_burst    = lat_bl;

endmodule

// File: rtl/brs_checker.sv
module brs_checker
    import brs_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int TRP    = 3,
    parameter int TRCD   = 3,
    localparam int NB    = 1 << BANK_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cmd_code,
    input logic [BANK_W-1:0] cmd_bank,
    input logic              req_ack,
    input logic              busy,
    input logic              pall_seen,
    input logic [NB-1:0]     open_vec
);
    localparam logic [7:0] TRP_C  = 8'(TRP);
    localparam logic [7:0] TRCD_C = 8'(TRCD);

    logic [7:0] since_pre, since_act;
    logic       is_col;

    assign is_col = (cmd_code == CMD_RD) || (cmd_code == CMD_WR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_pre <= 8'hFF;
            since_act <= 8'hFF;
        end else begin
            if (cmd_code == CMD_PRE)      since_pre <= 8'd1;
            else if (since_pre != 8'hFF)  since_pre <= since_pre + 8'd1;
            if (cmd_code == CMD_ACT)      since_act <= 8'd1;
            else if (since_act != 8'hFF)  since_act <= since_act + 8'd1;
        end
    end

    p_act_to_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_ACT) |-> !open_vec[cmd_bank]);

    p_pre_to_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_PRE) |-> open_vec[cmd_bank]);

    p_trp_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_ACT) |-> (since_pre >= TRP_C));

    p_trcd_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (since_act >= TRCD_C));

    p_ack_after_col_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |=> req_ack);

    p_ack_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (cmd_code == CMD_NOP) && busy);

    p_ack_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    p_pall_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pall_seen |=> (open_vec == '0));

endmodule

bind bank_row_sequencer brs_checker #(
    .BANK_W(BANK_W), .TRP(TRP), .TRCD(TRCD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_code  (cmd_code),
    .cmd_bank  (cmd_bank),
    .req_ack   (req_ack),
    .busy      (busy),
    .pall_seen (pall_seen),
    .open_vec  (open_vec)
);

// File: tb/bank_row_sequencer_tb.sv
module bank_row_sequencer_tb;
    localparam int BANK_W = 2, ROW_W = 12, COL_W = 8, BL_W = 4, TRP = 3, TRCD = 3;
    localparam int ADDR_W = BANK_W + ROW_W + COL_W;
    localparam int NOP = 0, PRE = 1, ACT = 2, RD = 3, WR = 4;
    localparam int NV = 12;

    // {wr, bank[2], row[12], col[8], ap, bl[4], pattern[2]}; pattern 0 hit, 1 act, 2 pre+act
    localparam logic [29:0] VEC [NV] = '{
        {1'b1, 2'd0, 12'd5,    8'd3,   1'b0, 4'd4, 2'd1},
        {1'b0, 2'd0, 12'd5,    8'd7,   1'b0, 4'd8, 2'd0},
        {1'b0, 2'd0, 12'd9,    8'd1,   1'b0, 4'd2, 2'd2},
        {1'b1, 2'd1, 12'd9,    8'd0,   1'b1, 4'd4, 2'd1},
        {1'b0, 2'd1, 12'd9,    8'd2,   1'b0, 4'd1, 2'd1},
        {1'b1, 2'd0, 12'd9,    8'd4,   1'b0, 4'd4, 2'd0},
        {1'b0, 2'd3, 12'd0,    8'd5,   1'b0, 4'd15, 2'd1},
        {1'b0, 2'd2, 12'd4095, 8'd255, 1'b0, 4'd4, 2'd1},
        {1'b1, 2'd0, 12'd9,    8'd6,   1'b1, 4'd4, 2'd0},
        {1'b0, 2'd0, 12'd9,    8'd8,   1'b0, 4'd4, 2'd1},
        {1'b0, 2'd1, 12'd9,    8'd9,   1'b0, 4'd4, 2'd0},
        {1'b1, 2'd2, 12'd4094, 8'd1,   1'b0, 4'd4, 2'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_req = 1'b0, rd_req = 1'b0, auto_close = 1'b0, pall_seen = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [BL_W-1:0] burst_len = '0;
    logic req_ack, busy, cmd_auto_pre;
    logic [2:0] cmd_code;
    logic [BANK_W-1:0] cmd_bank;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;
    logic [BL_W-1:0] cmd_burst;

    int total = 0;
    int fails = 0;
    int wd = 0;

    always #5 clk = ~clk;

    bank_row_sequencer #(
        .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .BL_W(BL_W), .TRP(TRP), .TRCD(TRCD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req), .req_addr(req_addr),
        .burst_len(burst_len), .auto_close(auto_close), .pall_seen(pall_seen),
        .req_ack(req_ack), .busy(busy), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_auto_pre(cmd_auto_pre), .cmd_burst(cmd_burst)
    );

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 100000) begin
            total++;
            fails++;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", wd);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_req(input bit wr, input bit rd, input logic [1:0] bank, input logic [11:0] row,
                          input logic [7:0] col, input bit ap, input logic [3:0] bl,
                          input int pat, input bit exp_wr);
        int cyc = 0, pre_c = -1, act_c = -1, col_c = -1, ack_c = -1;
        int n_pre = 0, n_act = 0, col_code = 0, col_col = 0, col_ap = 0, col_bl = 0;
        int col_bank = 0, act_row = 0, act_bank = 0, col_busy = 0;
        @(negedge clk);
        wr_req = wr; rd_req = rd; auto_close = ap; burst_len = bl;
        req_addr = {bank, row, col};
        while (ack_c < 0 && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (cmd_code == 3'(PRE)) begin n_pre++; pre_c = cyc; end
            if (cmd_code == 3'(ACT)) begin n_act++; act_c = cyc; act_row = int'(cmd_row); act_bank = int'(cmd_bank); end
            if (cmd_code == 3'(RD) || cmd_code == 3'(WR)) begin
                col_c = cyc; col_code = int'(cmd_code); col_col = int'(cmd_col);
                col_ap = int'(cmd_auto_pre); col_bl = int'(cmd_burst); col_bank = int'(cmd_bank);
                col_busy = int'(busy);
            end
            if (req_ack) begin
                ack_c = cyc;
                wr_req = 1'b0; rd_req = 1'b0;
            end
        end
        if (pat == 0) chk(n_pre == 0 && n_act == 0, "R4", "row hit extra cmds", n_pre + n_act, 0);
        if (pat == 1) chk(n_pre == 0 && n_act == 1, "R2", "closed bank act count", n_pre * 10 + n_act, 1);
        if (pat == 2) chk(n_pre == 1 && n_act == 1, "R3", "row miss pre/act count", n_pre * 10 + n_act, 11);
        if (n_act > 0) begin
            chk(act_row == int'(row), "R1", "activate row", act_row, int'(row));
            chk(act_bank == int'(bank), "R1", "activate bank", act_bank, int'(bank));
            chk(col_c - act_c == TRCD, "R5", "act to column gap", col_c - act_c, TRCD);
        end
        if (n_pre > 0) chk(act_c - pre_c == TRP, "R5", "pre to act gap", act_c - pre_c, TRP);
        chk(col_code == (exp_wr ? WR : RD), "R9", "column command code", col_code, exp_wr ? WR : RD);
        chk(col_col == int'(col) && col_bank == int'(bank), "R1", "column field", col_col, int'(col));
        chk(col_ap == int'(ap), "R7", "auto-precharge flag", col_ap, int'(ap));
        chk(col_bl == int'(bl), "R12", "burst length", col_bl, int'(bl));
        chk(col_busy == 1, "R11", "busy during column", col_busy, 1);
        chk(ack_c == col_c + 1, "R6", "ack cycle", ack_c, col_c + 1);
        @(negedge clk);
        chk(req_ack == 1'b0, "R6", "ack width", int'(req_ack), 0);
        chk(busy == 1'b0, "R11", "busy after ack", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(cmd_code == 3'(NOP), "R10", "reset cmd", int'(cmd_code), NOP);
        chk(req_ack == 1'b0, "R10", "reset ack", int'(req_ack), 0);
        chk(busy == 1'b0, "R10", "reset busy", int'(busy), 0);

        // Table walk (first entry relies on R10: all banks closed)
        for (int i = 0; i < NV; i++) begin
            do_req(VEC[i][29], !VEC[i][29], VEC[i][28:27], VEC[i][26:15], VEC[i][14:7],
                   VEC[i][6], VEC[i][5:2], int'(VEC[i][1:0]), VEC[i][29]);
        end

        // R8: precharge-all closes every bank
        @(negedge clk);
        pall_seen = 1'b1;
        @(negedge clk);
        pall_seen = 1'b0;
        do_req(1'b0, 1'b1, 2'd1, 12'd9, 8'd3, 1'b0, 4'd2, 1, 1'b0);   // was open on row 9: R8
        // R9: both requests raised, the write is taken
        do_req(1'b1, 1'b1, 2'd3, 12'd0, 8'd4, 1'b0, 4'd2, 1, 1'b1);
        // R4 after R8 reopen
        do_req(1'b0, 1'b1, 2'd3, 12'd0, 8'd5, 1'b1, 4'd3, 0, 1'b0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule